// File: doc/BRIEF.md
# CAN Bus-Off Recovery Sequencer

This block decides when a CAN node may take part in bus traffic. When the error counter logic reports that the node has gone bus-off, the block sets its initialization flag by itself and holds the protocol engine quiet. From then on it waits for the CPU to clear that flag. Clearing the flag does not release the bus at once. It starts a fixed recovery wait instead: the node must see 129 idle periods, and each idle period is a run of 11 consecutive recessive bits. Each time one run completes, the block writes the stuck-at-dominant error code into the status register's last error code field. Software can watch that field to follow progress, or to spot a bus that is held dominant. At the end of the wait the block pulses a reset to the error counters and returns to normal operation.

The initialization flag is owned by the CAN clock domain but is written and read from the CPU clock domain. A write travels over a toggle request/acknowledge handshake. The read port shows the CAN-side value after a two-flop synchronizer, so a write becomes visible only some cycles later. A second write issued before the first has been acknowledged is dropped. Software should read the flag back before it writes the flag again.

Top module: `can_boff_recovery`

## Requirements
- R1: After reset the initialization flag is 1 in both domains. `bus_halt_o` is 1, and `lec_we_o` and `err_cnt_rst_o` are 0.
- R2: A `boff_trig_i` pulse sampled while in normal operation sets `init_o` and `bus_halt_o` from the next CAN clock cycle. A trigger sampled while bus-off or while recovering has no effect.
- R3: While bus-off, recovery begins only on a CPU write of 0 to the flag. A CPU write of 1 keeps the node bus-off, and bit strobes produce no `lec_we_o` pulse.
- R4: During recovery, every 11th consecutive recessive bit (`rx_bit_i`=1 sampled with `bit_strobe_i`=1) produces a one-cycle `lec_we_o` pulse with `lec_code_o`=3'b101. The pulse appears in the cycle after the clock edge that samples that strobe. At all other times `lec_code_o` is 3'b000.
- R5: A dominant bit (`rx_bit_i`=0) strobed during recovery restarts the 11-bit run but keeps the number of runs already completed.
- R6: The `lec_we_o` pulse of the 129th run comes together with a one-cycle `err_cnt_rst_o` pulse. From the next cycle `bus_halt_o` follows the flag alone.
- R7: CPU writes to the flag during recovery change `init_o` and the read-back value, but they neither restart nor shorten the 129-run count.
- R8: A CPU write reaches `init_o` through the handshake, and `cpu_init_rdata_o` then reports it. A write presented while an earlier write is still unacknowledged is discarded.
- R9: Outside recovery, bit strobes never cause `lec_we_o` or `err_cnt_rst_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | CPU register clock |
| cpu_rst_n | input | 1 | CPU domain reset, active low |
| cpu_init_we | input | 1 | Write strobe for the initialization flag |
| cpu_init_wdata | input | 1 | Value to write into the flag |
| cpu_init_rdata_o | output | 1 | Synchronized read-back of the flag |
| can_clk | input | 1 | CAN core clock |
| can_rst_n | input | 1 | CAN domain reset, active low |
| boff_trig_i | input | 1 | Bus-off event from the error counters |
| bit_strobe_i | input | 1 | One-cycle strobe per sampled bus bit |
| rx_bit_i | input | 1 | Sampled bus level, 1 = recessive |
| init_o | output | 1 | Initialization flag, CAN domain |
| bus_halt_o | output | 1 | Holds the protocol engine off the bus |
| lec_we_o | output | 1 | Write strobe into the last error code field |
| lec_code_o | output | 3 | Error code value to write |
| err_cnt_rst_o | output | 1 | Reset pulse for the error counters |

## Verification
The bench aims at the edges of the run count. One test places a dominant bit right after ten recessive ones; a design that cleared the run count too late would report a run early. Another test sends exactly 1419 recessive bits; a design that was off by one in either counter would raise the counter reset one run early or late. Flag writes and bus-off triggers are injected in the middle of recovery. A design that restarted the wait or released the bus early would then show a wrong pulse position or a low halt. Two flag writes are sent back to back; a handshake that let the second overrun the first would leave the wrong value in the CAN domain.

// File: rtl/boff_rec_pkg.sv
package boff_rec_pkg;
    typedef enum logic [1:0] {
        ST_NORMAL  = 2'd0,
        ST_BUSOFF  = 2'd1,
        ST_RECOVER = 2'd2
    } rec_state_e;

    localparam int unsigned LEC_W = 3;
    localparam logic [LEC_W-1:0] LEC_NONE = 3'b000;
    localparam logic [LEC_W-1:0] LEC_BIT0 = 3'b101;
endpackage

// File: rtl/init_cdc.sv
module init_cdc (
    input  logic cpu_clk,
    input  logic cpu_rst_n,
    input  logic cpu_we_i,
    input  logic cpu_wdata_i,
    output logic cpu_rdata_o,
    input  logic can_clk,
    input  logic can_rst_n,
    input  logic can_init_i,
    output logic can_wr_ev_o,
    output logic can_wr_val_o
);
    typedef struct packed {
        logic req_tgl;
        logic wval;
        logic ack_s1;
        logic ack_s2;
        logic rb_s1;
        logic rb_s2;
    } cpu_regs_t;

    typedef struct packed {
        logic req_s1;
        logic req_s2;
        logic ack_tgl;
    } can_regs_t;

    cpu_regs_t cpu_d, cpu_q;
    can_regs_t can_d, can_q;
    logic      pending;

    // CPU side: hold the request until the acknowledge toggle returns
    always_comb begin
        cpu_d        = cpu_q;
        pending      = cpu_q.req_tgl != cpu_q.ack_s2;
        cpu_d.ack_s1 = can_q.ack_tgl;
        cpu_d.ack_s2 = cpu_q.ack_s1;
        cpu_d.rb_s1  = can_init_i;
        cpu_d.rb_s2  = cpu_q.rb_s1;
        if (cpu_we_i && !pending) begin
            cpu_d.wval    = cpu_wdata_i;
            cpu_d.req_tgl = ~cpu_q.req_tgl;
        end
    end

    always_ff @(posedge cpu_clk or negedge cpu_rst_n) begin
        if (!cpu_rst_n) begin
            cpu_q <= '{req_tgl: 1'b0, wval: 1'b1, ack_s1: 1'b0, ack_s2: 1'b0,
                       rb_s1: 1'b1, rb_s2: 1'b1};
        end else begin
            cpu_q <= cpu_d;
        end
    end

    assign cpu_rdata_o = cpu_q.rb_s2;

    // CAN side: a toggle edge delivers one write event
    always_comb begin
        can_d        = can_q;
        can_d.req_s1 = cpu_q.req_tgl;
        can_d.req_s2 = can_q.req_s1;
        can_wr_ev_o  = can_q.req_s2 != can_q.ack_tgl;
        if (can_wr_ev_o) begin
            can_d.ack_tgl = can_q.req_s2;
        end
    end

    always_ff @(posedge can_clk or negedge can_rst_n) begin
        if (!can_rst_n) begin
            can_q <= '0;
        end else begin
            can_q <= can_d;
        end
    end

    assign can_wr_val_o = cpu_q.wval;

    a_r8_drop_while_pending: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
        (cpu_we_i && pending) |=> ($stable(cpu_q.req_tgl) && $stable(cpu_q.wval)));

    a_r8_single_event: assert property (@(posedge can_clk) disable iff (!can_rst_n)
        can_wr_ev_o |=> !can_wr_ev_o);
endmodule

// File: rtl/idle_run_det.sv
module idle_run_det #(
    parameter int unsigned RUN_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic stb_i,
    input  logic rx_i,
    output logic done_o
);
    localparam int unsigned CW = $clog2(RUN_BITS + 1);
    localparam logic [CW-1:0] LAST = CW'(RUN_BITS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } run_regs_t;

    run_regs_t d, q;

    always_comb begin
        d      = q;
        done_o = 1'b0;
        if (!en_i) begin
            d.cnt = '0;
        end else if (stb_i) begin
            if (!rx_i) begin
                d.cnt = '0;
            end else if (q.cnt == LAST) begin
                d.cnt  = '0;
                done_o = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    a_r5_dominant_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && stb_i && !rx_i) |=> (q.cnt == '0));

    a_r4_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= LAST);
endmodule

// File: rtl/rec_seq.sv
module rec_seq
    import boff_rec_pkg::*;
#(
    parameter int unsigned RUN_COUNT = 129
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boff_i,
    input  logic             wr_ev_i,
    input  logic             wr_val_i,
    input  logic             run_done_i,
    input  logic             bit_stb_i,
    input  logic             rx_i,
    output logic             recovering_o,
    output logic             init_o,
    output logic             halt_o,
    output logic             lec_we_o,
    output logic [LEC_W-1:0] lec_code_o,
    output logic             cnt_rst_o
);
    localparam int unsigned PW = $clog2(RUN_COUNT + 1);
    localparam logic [PW-1:0] LAST = PW'(RUN_COUNT - 1);

    typedef struct packed {
        rec_state_e       state;
        logic             init;
        logic [PW-1:0]    periods;
        logic             lec_we;
        logic [LEC_W-1:0] lec_code;
        logic             cnt_rst;
    } seq_regs_t;

    seq_regs_t d, q;

    always_comb begin
        d          = q;
        d.lec_we   = 1'b0;
        d.lec_code = LEC_NONE;
        d.cnt_rst  = 1'b0;
        if (wr_ev_i) begin
            d.init = wr_val_i;
        end
        unique case (q.state)
            ST_NORMAL: begin
                if (boff_i) begin
                    d.state = ST_BUSOFF;
                    d.init  = 1'b1;
                end
            end
            ST_BUSOFF: begin
                if (wr_ev_i && !wr_val_i) begin
                    d.state   = ST_RECOVER;
                    d.periods = '0;
                end
            end
            ST_RECOVER: begin
                if (run_done_i) begin
                    d.lec_we   = 1'b1;
                    d.lec_code = LEC_BIT0;
                    if (q.periods == LAST) begin
                        d.cnt_rst = 1'b1;
                        d.periods = '0;
                        d.state   = ST_NORMAL;
                    end else begin
                        d.periods = q.periods + 1'b1;
                    end
                end
            end
            default: d.state = ST_NORMAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_NORMAL, init: 1'b1, periods: '0, lec_we: 1'b0,
                   lec_code: LEC_NONE, cnt_rst: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign recovering_o = q.state == ST_RECOVER;
    assign init_o       = q.init;
    assign halt_o       = q.init || (q.state != ST_NORMAL);
    assign lec_we_o     = q.lec_we;
    assign lec_code_o   = q.lec_code;
    assign cnt_rst_o    = q.cnt_rst;

    a_r2_boff_sets_init: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_NORMAL && boff_i) |=> (init_o && halt_o));

    a_r4_lec_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
        lec_we_o |-> $past(bit_stb_i && rx_i));

    a_r6_rst_with_lec: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rst_o |-> (lec_we_o && lec_code_o == LEC_BIT0));

    a_r9_quiet_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state != ST_RECOVER) |=> (!lec_we_o && !cnt_rst_o));

    a_r7_no_shortcut: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_RECOVER && !run_done_i) |=> (q.state == ST_RECOVER && $stable(q.periods)));
endmodule

// File: rtl/can_boff_recovery.sv
module can_boff_recovery
    import boff_rec_pkg::*;
#(
    parameter int unsigned RUN_BITS  = 11,
    parameter int unsigned RUN_COUNT = 129
) (
    input  logic             cpu_clk,
    input  logic             cpu_rst_n,
    input  logic             cpu_init_we,
    input  logic             cpu_init_wdata,
    output logic             cpu_init_rdata_o,
    input  logic             can_clk,
    input  logic             can_rst_n,
    input  logic             boff_trig_i,
    input  logic             bit_strobe_i,
    input  logic             rx_bit_i,
    output logic             init_o,
    output logic             bus_halt_o,
    output logic             lec_we_o,
    output logic [LEC_W-1:0] lec_code_o,
    output logic             err_cnt_rst_o
);
    logic wr_ev, wr_val, run_done, recovering, init_w;

    init_cdc u_cdc (
        .cpu_clk      (cpu_clk),
        .cpu_rst_n    (cpu_rst_n),
        .cpu_we_i     (cpu_init_we),
        .cpu_wdata_i  (cpu_init_wdata),
        .cpu_rdata_o  (cpu_init_rdata_o),
        .can_clk      (can_clk),
        .can_rst_n    (can_rst_n),
        .can_init_i   (init_w),
        .can_wr_ev_o  (wr_ev),
        .can_wr_val_o (wr_val)
    );

    idle_run_det #(.RUN_BITS(RUN_BITS)) u_run (
        .clk    (can_clk),
        .rst_n  (can_rst_n),
        .en_i   (recovering),
        .stb_i  (bit_strobe_i),
        .rx_i   (rx_bit_i),
        .done_o (run_done)
    );

    rec_seq #(.RUN_COUNT(RUN_COUNT)) u_seq (
        .clk          (can_clk),
        .rst_n        (can_rst_n),
        .boff_i       (boff_trig_i),
        .wr_ev_i      (wr_ev),
        .wr_val_i     (wr_val),
        .run_done_i   (run_done),
        .bit_stb_i    (bit_strobe_i),
        .rx_i         (rx_bit_i),
        .recovering_o (recovering),
        .init_o       (init_w),
        .halt_o       (bus_halt_o),
        .lec_we_o     (lec_we_o),
        .lec_code_o   (lec_code_o),
        .cnt_rst_o    (err_cnt_rst_o)
    );

    assign init_o = init_w;

    a_r1_free_only_when_clear: assert property (@(posedge can_clk) disable iff (!can_rst_n)
        !bus_halt_o |-> (!init_o && !recovering));
endmodule

// File: tb/tb_can_boff_recovery.sv
module tb_can_boff_recovery;
    logic       cpu_clk = 1'b0, can_clk = 1'b0;
    logic       cpu_rst_n = 1'b0, can_rst_n = 1'b0;
    logic       cpu_init_we = 1'b0, cpu_init_wdata = 1'b0;
    logic       boff_trig_i = 1'b0, bit_strobe_i = 1'b0, rx_bit_i = 1'b1;
    logic       cpu_init_rdata_o, init_o, bus_halt_o, lec_we_o, err_cnt_rst_o;
    logic [2:0] lec_code_o;

    int checks = 0, failures = 0;
    int m_state = 0;   // 0 normal, 1 bus-off, 2 recovering
    bit m_init = 1'b1;
    int m_bits = 0, m_runs = 0;

    always #10 cpu_clk = ~cpu_clk;   // 50 MHz
    always #15 can_clk = ~can_clk;

    can_boff_recovery dut (.*);

    function automatic bit exp_halt();
        return m_init || (m_state != 0);
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic send_bit(input bit b, input string req);
        bit done, last;
        @(negedge can_clk);
        bit_strobe_i = 1'b1;
        rx_bit_i     = b;
        done = 0; last = 0;
        if (m_state == 2) begin
            if (!b) m_bits = 0;
            else if (m_bits == 10) begin
                m_bits = 0; done = 1;
                if (m_runs == 128) begin last = 1; m_runs = 0; m_state = 0; end
                else m_runs++;
            end else m_bits++;
        end
        @(negedge can_clk);
        bit_strobe_i = 1'b0;
        rx_bit_i     = 1'b1;
        check(lec_we_o == done, req, "lec_we", lec_we_o, done);
        check(lec_code_o == (done ? 3'b101 : 3'b000), req, "lec_code", lec_code_o, done ? 5 : 0);
        check(err_cnt_rst_o == last, "R6", "err_cnt_rst", err_cnt_rst_o, last);
        check(bus_halt_o == exp_halt(), req, "bus_halt", bus_halt_o, exp_halt());
        repeat ($urandom % 3) @(negedge can_clk);
    endtask

    task automatic settle_check(input string req);
        repeat (20) @(negedge cpu_clk);
        check(cpu_init_rdata_o == m_init, req, "readback", cpu_init_rdata_o, m_init);
        check(init_o == m_init, req, "init", init_o, m_init);
        check(bus_halt_o == exp_halt(), req, "bus_halt", bus_halt_o, exp_halt());
    endtask

    task automatic cpu_write(input bit v, input string req);
        @(negedge cpu_clk);
        cpu_init_we = 1'b1; cpu_init_wdata = v;
        @(negedge cpu_clk);
        cpu_init_we = 1'b0;
        if (m_state == 1 && !v) begin m_state = 2; m_bits = 0; m_runs = 0; end
        m_init = v;
        settle_check(req);
    endtask

    task automatic bus_off(input string req);
        @(negedge can_clk);
        boff_trig_i = 1'b1;
        @(negedge can_clk);
        boff_trig_i = 1'b0;
        if (m_state == 0) begin m_state = 1; m_init = 1'b1; end
        check(init_o == m_init, req, "init after trigger", init_o, m_init);
        check(bus_halt_o == exp_halt(), req, "halt after trigger", bus_halt_o, exp_halt());
    endtask

    initial begin
        #4_000_000;
        failures++;
        $display("FAIL watchdog expired checks=%0d", checks);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge can_clk);
        cpu_rst_n = 1'b1; can_rst_n = 1'b1;
        @(negedge cpu_clk);
        // R1 reset state
        check(cpu_init_rdata_o == 1'b1, "R1", "readback", cpu_init_rdata_o, 1);
        check(init_o == 1'b1, "R1", "init", init_o, 1);
        check(bus_halt_o == 1'b1, "R1", "halt", bus_halt_o, 1);
        check(!lec_we_o && !err_cnt_rst_o, "R1", "pulses", lec_we_o | err_cnt_rst_o, 0);

        cpu_write(1'b0, "R8");
        for (int i = 0; i < 25; i++) send_bit($urandom % 2, "R9");

        bus_off("R2");
        for (int i = 0; i < 40; i++) send_bit(1'b1, "R3");
        cpu_write(1'b1, "R3");
        for (int i = 0; i < 15; i++) send_bit(1'b1, "R3");
        cpu_write(1'b0, "R3");

        // R5: dominant after ten recessive restarts the run
        for (int i = 0; i < 10; i++) send_bit(1'b1, "R5");
        send_bit(1'b0, "R5");
        for (int i = 0; i < 11; i++) send_bit(1'b1, "R5");
        bus_off("R2");
        for (int i = 0; i < 300; i++) send_bit(($urandom % 8) != 0, "R4");
        cpu_write(1'b1, "R7");
        for (int i = 0; i < 200; i++) send_bit(($urandom % 8) != 0, "R7");
        cpu_write(1'b0, "R7");
        for (int i = 0; i < 30000 && m_state == 2; i++) send_bit(($urandom % 8) != 0, "R4");
        check(m_state == 0, "R6", "recovery finished", m_state, 0);
        settle_check("R6");

        // R8: second write while the first is unacknowledged is dropped
        @(negedge cpu_clk);
        cpu_init_we = 1'b1; cpu_init_wdata = 1'b1;
        @(negedge cpu_clk);
        cpu_init_wdata = 1'b0;
        @(negedge cpu_clk);
        cpu_init_we = 1'b0;
        m_init = 1'b1;
        settle_check("R8");
        cpu_write(1'b0, "R8");

        // exact 129 x 11 recessive bits, finishing with the flag set
        bus_off("R2");
        cpu_write(1'b0, "R3");
        for (int i = 0; i < 700; i++) send_bit(1'b1, "R4");
        cpu_write(1'b1, "R7");
        for (int i = 0; i < 718; i++) send_bit(1'b1, "R7");
        check(m_state == 2, "R7", "still recovering before last bit", m_state, 2);
        send_bit(1'b1, "R6");
        check(bus_halt_o == 1'b1, "R6", "halt held by flag", bus_halt_o, 1);
        cpu_write(1'b0, "R6");
        for (int i = 0; i < 12; i++) send_bit(1'b1, "R9");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule